// File: doc/BRIEF.md
# Quad-Page Translation Cache with Line Shootdown

This block is the translation cache that sits in front of the table walker of a two-level I/O address translator using 4 KB pages. Each of its lines holds four page table entries for four consecutive virtual pages. The line is tagged by the virtual page number with its two lowest bits dropped, and those two bits pick the entry within the line. A requester presents a virtual page number on the lookup port. One cycle later the block answers with either a hit pulse and the cached entry, or a miss pulse. The walker then installs a whole four-entry line through the refill port.

Entries can be removed in two ways. Software may write a shootdown command to a register. This drops the one line that covers a given line-aligned page number, and while it works, bit 31 of the same register reads as one. A separate clear request invalidates every line, and a clearing status stays up until the last line is gone. Each cached entry is a 32-bit word. Bits 31:30 hold a page-size code, bit 29 is writable, bit 28 is valid, and bits 27:0 are the physical page number. The cache stores and returns this word unchanged.

Top module: `iotlb_quad`

## Requirements
- R1: After reset every line is invalid, so every lookup misses, `clr_busy` is low, and a read at offset 0x18 returns zero.
- R2: Each cycle with `lk_valid` high produces exactly one response in the next cycle, either `rsp_hit` or `rsp_miss`. Neither is high in a cycle that follows a cycle without a lookup.
- R3: A lookup hits only when a valid line's tag equals `lk_vpn >> 2`. On a miss `rsp_pte` is zero.
- R4: On a hit, `rsp_pte` is refill lane `lk_vpn[1:0]` of the matching line, where lane k occupies `fill_line[32k+31:32k]`. All 32 bits, including the size code in 31:30, the writable flag in 29, the valid flag in 28 and the frame in 27:0, come back unchanged.
- R5: A refill whose tag is not resident goes to the line at a round-robin pointer that starts at line 0 and advances by one per such refill, wrapping after the last line. With 8 lines, the ninth distinct tag evicts the first.
- R6: A refill whose tag is already resident overwrites that line in place. The pointer does not advance and no other line is evicted.
- R7: A register write at offset 0x18 with bit 30 set invalidates the resident line whose tag equals the page field `wdata[29:2]`. Bits 1:0 of the write are ignored, and all other lines are untouched.
- R8: After such a write, bit 31 of a read at offset 0x18 is one for exactly two cycles and then zero. All other read bits are zero.
- R9: A pulse on `clr_req` raises `clr_busy` for exactly LINES cycles (8 by default), after which every lookup misses.
- R10: The following writes and requests change nothing: a write at 0x18 with bit 30 clear, a write at any other offset, a shootdown write while a shootdown is busy, and a clear request while a clear is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| rsp_hit | output | 1 | One-cycle hit pulse for the previous lookup |
| rsp_miss | output | 1 | One-cycle miss pulse for the previous lookup |
| rsp_pte | output | 32 | Cached entry on a hit, zero on a miss |
| fill_valid | input | 1 | Refill request |
| fill_vpn | input | VPN_W | Any page number inside the line being refilled |
| fill_line | input | 128 | Four entries, lane k for page offset k |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| clr_req | input | 1 | Request to invalidate the whole cache |
| clr_busy | output | 1 | High while the whole-cache clear runs |

## Verification
Directed lookups cover all four lanes of one line and the neighbouring line tags. These show whether the tag shift and the lane select are wired correctly. Refills of nine distinct tags, and of a tag that is already resident, separate round-robin victim choice from in-place overwrite. Shootdowns with nonzero low bits, with bit 30 clear, at a foreign offset and during a busy window show whether exactly one line is dropped and whether the two-cycle busy timing holds. A random mix of refills, lookups and shootdowns over a small tag set, checked against a bench model, brings out eviction and invalidation orderings that the directed cases do not reach.

// File: rtl/iotlb_quad_pkg.sv
package iotlb_quad_pkg;
  localparam int unsigned PTE_W    = 32;
  localparam int unsigned LANES    = 4;
  localparam int unsigned REG_AW   = 8;
  localparam logic [7:0]  SD_OFS   = 8'h18;
  localparam int unsigned SD_GO    = 30;
  localparam int unsigned SD_BUSY  = 31;

  // Decode of a register write that starts a line shootdown.
  function automatic logic sd_start(input logic wr, input logic [7:0] addr,
                                    input logic [31:0] wdata);
    return wr && (addr == SD_OFS) && wdata[SD_GO];
  endfunction
endpackage

// File: rtl/iotlb_quad_store.sv
module iotlb_quad_store
  import iotlb_quad_pkg::*;
#(
  parameter int unsigned LINES = 8,
  parameter int unsigned TAG_W = 22,
  localparam int unsigned IDX_W  = $clog2(LINES),
  localparam int unsigned LINE_W = LANES * PTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TAG_W-1:0]  lk_tag,
  input  logic [27:0]       sd_page,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic              fill_we,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [LINE_W-1:0] fill_line,
  input  logic [LINES-1:0]  inv_mask,
  output logic [LINES-1:0]  lk_match,
  output logic [LINES-1:0]  sd_match,
  output logic [LINES-1:0]  fill_match,
  output logic [LINE_W-1:0] lk_line
);
  logic [LINES-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [LINE_W-1:0] data_q [LINES];
  logic [LINES-1:0]  fill_oh;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign lk_match[i]   = valid_q[i] && (tag_q[i] == lk_tag);
    assign fill_match[i] = valid_q[i] && (tag_q[i] == fill_tag);
    assign sd_match[i]   = valid_q[i] && (28'(tag_q[i]) == sd_page);
    assign fill_oh[i]    = fill_we && (fill_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tag_q[i]  <= '0;
        data_q[i] <= '0;
      end else if (fill_oh[i]) begin
        tag_q[i]  <= fill_tag;
        data_q[i] <= fill_line;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= (valid_q | fill_oh) & ~inv_mask;
  end

  always_comb begin
    lk_line = '0;
    for (int i = 0; i < LINES; i++)
      lk_line = lk_line | (data_q[i] & {LINE_W{lk_match[i]}});
  end
endmodule

// File: rtl/iotlb_quad_victim.sv
module iotlb_quad_victim #(
  parameter int unsigned LINES = 8,
  localparam int unsigned IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_valid,
  input  logic [LINES-1:0] fill_match,
  output logic [IDX_W-1:0] fill_idx,
  output logic             fill_reuse
);
  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] match_idx;

  function automatic logic [IDX_W-1:0] ptr_next(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(LINES - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    match_idx = '0;
    for (int i = 0; i < LINES; i++)
      if (fill_match[i]) match_idx = IDX_W'(i);
  end

  assign fill_reuse = |fill_match;
  assign fill_idx   = fill_reuse ? match_idx : ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                         ptr_q <= '0;
    else if (fill_valid && !fill_reuse) ptr_q <= ptr_next(ptr_q);
  end
endmodule

// File: rtl/iotlb_quad_inval.sv
module iotlb_quad_inval
  import iotlb_quad_pkg::*;
#(
  parameter int unsigned LINES = 8,
  localparam int unsigned IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [7:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  input  logic             clr_req,
  input  logic [LINES-1:0] sd_match,
  output logic [27:0]      sd_page,
  output logic             sd_busy,
  output logic             clr_busy,
  output logic [LINES-1:0] inv_mask
);
  logic             sd_phase_q;
  logic [IDX_W-1:0] clr_idx_q;
  logic             sd_go;
  logic             sd_apply;
  logic [LINES-1:0] clr_oh;

  assign sd_go    = sd_start(reg_wr, reg_addr, reg_wdata) && !sd_busy;
  assign sd_apply = sd_busy && !sd_phase_q;

  for (genvar i = 0; i < LINES; i++) begin : g_clr
    assign clr_oh[i] = clr_busy && (clr_idx_q == IDX_W'(i));
  end

  assign inv_mask = clr_oh | (sd_match & {LINES{sd_apply}});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sd_busy    <= 1'b0;
      sd_phase_q <= 1'b0;
      sd_page    <= '0;
    end else if (sd_go) begin
      sd_busy    <= 1'b1;
      sd_phase_q <= 1'b0;
      sd_page    <= reg_wdata[29:2];
    end else if (sd_apply) begin
      sd_phase_q <= 1'b1;
    end else if (sd_busy) begin
      sd_busy    <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clr_busy  <= 1'b0;
      clr_idx_q <= '0;
    end else if (!clr_busy) begin
      clr_busy  <= clr_req;
      clr_idx_q <= '0;
    end else if (clr_idx_q == IDX_W'(LINES - 1)) begin
      clr_busy  <= 1'b0;
    end else begin
      clr_idx_q <= clr_idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/iotlb_quad.sv
module iotlb_quad
  import iotlb_quad_pkg::*;
#(
  parameter int unsigned LINES = 8,
  parameter int unsigned VPN_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             rsp_hit,
  output logic             rsp_miss,
  output logic [31:0]      rsp_pte,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [127:0]     fill_line,
  input  logic             reg_wr,
  input  logic [7:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             clr_req,
  output logic             clr_busy
);
  localparam int unsigned TAG_W  = VPN_W - 2;
  localparam int unsigned IDX_W  = $clog2(LINES);
  localparam int unsigned LINE_W = LANES * PTE_W;

  function automatic logic [TAG_W-1:0] line_tag(input logic [VPN_W-1:0] v);
    return v[VPN_W-1:2];
  endfunction

  function automatic logic [PTE_W-1:0] lane_pick(input logic [LINE_W-1:0] l,
                                                 input logic [1:0] sel);
    return l[sel*PTE_W +: PTE_W];
  endfunction

  logic [LINES-1:0]  lk_match, sd_match, fill_match, inv_mask;
  logic [LINE_W-1:0] lk_line;
  logic [IDX_W-1:0]  fill_idx;
  logic              fill_reuse;
  logic [27:0]       sd_page;
  logic              sd_busy;
  logic              lk_any;

  iotlb_quad_store #(.LINES(LINES), .TAG_W(TAG_W)) store_i (
    .clk, .rst_n,
    .lk_tag    (line_tag(lk_vpn)),
    .sd_page   (sd_page),
    .fill_tag  (line_tag(fill_vpn)),
    .fill_we   (fill_valid),
    .fill_idx  (fill_idx),
    .fill_line (fill_line),
    .inv_mask  (inv_mask),
    .lk_match  (lk_match),
    .sd_match  (sd_match),
    .fill_match(fill_match),
    .lk_line   (lk_line)
  );

  iotlb_quad_victim #(.LINES(LINES)) victim_i (
    .clk, .rst_n,
    .fill_valid(fill_valid),
    .fill_match(fill_match),
    .fill_idx  (fill_idx),
    .fill_reuse(fill_reuse)
  );

  iotlb_quad_inval #(.LINES(LINES)) inval_i (
    .clk, .rst_n,
    .reg_wr, .reg_addr, .reg_wdata, .clr_req,
    .sd_match(sd_match),
    .sd_page (sd_page),
    .sd_busy (sd_busy),
    .clr_busy(clr_busy),
    .inv_mask(inv_mask)
  );

  assign lk_any = |lk_match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_hit  <= 1'b0;
      rsp_miss <= 1'b0;
      rsp_pte  <= '0;
    end else begin
      rsp_hit  <= lk_valid && lk_any;
      rsp_miss <= lk_valid && !lk_any;
      if (lk_valid) rsp_pte <= lane_pick(lk_line, lk_vpn[1:0]);
    end
  end

  assign reg_rdata = (reg_addr == SD_OFS) ? {sd_busy, 31'b0} : 32'b0;
endmodule

// File: rtl/iotlb_quad_chk.sv
module iotlb_quad_chk #(
  parameter int unsigned LINES = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic             rsp_hit,
  input logic             rsp_miss,
  input logic [LINES-1:0] lk_match,
  input logic             sd_busy,
  input logic             clr_busy
);
  logic [7:0] clr_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)        clr_cnt <= '0;
    else if (clr_busy) clr_cnt <= clr_cnt + 1'b1;
    else               clr_cnt <= '0;
  end

  p_resp_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_hit && rsp_miss));
  p_resp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> (rsp_hit || rsp_miss));
  p_resp_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !(rsp_hit || rsp_miss));
  p_single_owner_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));
  p_sd_second_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sd_busy) |=> sd_busy);
  p_sd_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_busy && $past(sd_busy)) |=> !sd_busy);
  p_clr_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_cnt <= 8'(LINES));
endmodule

bind iotlb_quad iotlb_quad_chk #(.LINES(LINES)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .lk_valid(lk_valid),
  .rsp_hit (rsp_hit),
  .rsp_miss(rsp_miss),
  .lk_match(lk_match),
  .sd_busy (sd_busy),
  .clr_busy(clr_busy)
);

// File: tb/iotlb_quad_tb_top.sv
module iotlb_quad_tb_top;
  localparam int LINES = 8;
  localparam int VPN_W = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_valid = 1'b0, fill_valid = 1'b0, reg_wr = 1'b0, clr_req = 1'b0;
  logic [VPN_W-1:0] lk_vpn = '0, fill_vpn = '0;
  logic [127:0] fill_line = '0;
  logic [7:0]   reg_addr = 8'h18;
  logic [31:0]  reg_wdata = '0;
  logic rsp_hit, rsp_miss, clr_busy;
  logic [31:0] rsp_pte, reg_rdata;

  iotlb_quad #(.LINES(LINES), .VPN_W(VPN_W)) dut_i (.*);

  always #10 clk = ~clk;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  // bench model
  bit          m_val [LINES];
  int unsigned m_tag [LINES];
  logic [127:0] m_dat [LINES];
  int          m_ptr = 0;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      failures++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<100000", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic tick(); @(posedge clk); @(negedge clk); endtask

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int m_find(int unsigned tag);
    for (int i = 0; i < LINES; i++) if (m_val[i] && m_tag[i] == tag) return i;
    return -1;
  endfunction

  function automatic logic [31:0] lane(logic [127:0] l, int k);
    return l[k*32 +: 32];
  endfunction

  task automatic fill(int unsigned vpn, logic [127:0] dat);
    int idx;
    fill_valid = 1; fill_vpn = VPN_W'(vpn); fill_line = dat;
    tick();
    fill_valid = 0;
    idx = m_find(vpn >> 2);
    if (idx < 0) begin idx = m_ptr; m_ptr = (m_ptr + 1) % LINES; end
    m_val[idx] = 1; m_tag[idx] = vpn >> 2; m_dat[idx] = dat;
  endtask

  task automatic look(int unsigned vpn, string req);
    int idx;
    logic [33:0] exp, act;
    lk_valid = 1; lk_vpn = VPN_W'(vpn);
    tick();
    lk_valid = 0;
    idx = m_find(vpn >> 2);
    exp = (idx < 0) ? {2'b01, 32'h0} : {2'b10, lane(m_dat[idx], vpn & 3)};
    act = {rsp_hit, rsp_miss, rsp_pte};
    chk(act === exp, req, "lookup {hit,miss,pte}", 64'(act), 64'(exp));
  endtask

  task automatic reg_write(logic [7:0] a, logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 0; reg_addr = 8'h18;
  endtask

  task automatic shoot(int unsigned tag, logic [1:0] low, bit timing);
    reg_write(8'h18, 32'h4000_0000 | (tag << 2) | 32'(low));
    if (timing) chk(reg_rdata === 32'h8000_0000, "R8", "busy cycle 1", 64'(reg_rdata), 64'h8000_0000);
    tick();
    if (timing) chk(reg_rdata === 32'h8000_0000, "R8", "busy cycle 2", 64'(reg_rdata), 64'h8000_0000);
    tick();
    if (timing) chk(reg_rdata === 32'h0, "R8", "busy ends", 64'(reg_rdata), 64'h0);
    for (int i = 0; i < LINES; i++) if (m_tag[i] == tag) m_val[i] = 0;
  endtask

  function automatic logic [127:0] rnd_line();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic run_clear(bit rerequest, output int cnt);
    clr_req = 1; tick(); clr_req = 0;
    cnt = 0;
    while (clr_busy && cnt < 50) begin
      cnt++;
      if (rerequest && cnt == 3) clr_req = 1;
      tick();
      clr_req = 0;
    end
    for (int i = 0; i < LINES; i++) m_val[i] = 0;
  endtask

  initial begin
    int cnt;
    logic [127:0] d;
    void'($urandom(32'd20240607));
    for (int i = 0; i < LINES; i++) begin m_val[i] = 0; m_tag[i] = 0; m_dat[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk(reg_rdata === 32'h0, "R1", "rdata after reset", 64'(reg_rdata), 64'h0);
    chk(clr_busy === 1'b0, "R1", "clr_busy after reset", 64'(clr_busy), 64'h0);
    look(32'h123, "R1");

    // R3/R4 all four lanes, PTE fields pass through
    d = {32'hF000_0ABC, 32'h2000_1234, 32'h1FFF_FFFF, 32'h7123_4567};
    fill(32'h400, d);
    for (int k = 0; k < 4; k++) look(32'h400 + k, "R4");
    look(32'h404, "R3");
    look(32'h3FF, "R3");
    // R2 no response without a lookup
    tick();
    chk({rsp_hit, rsp_miss} === 2'b00, "R2", "quiet without lookup", 64'({rsp_hit, rsp_miss}), 64'h0);

    // R5 round robin: 8 more distinct tags, first one evicted
    for (int t = 1; t <= 8; t++) fill(32'h400 + 4*t, rnd_line());
    look(32'h401, "R5");
    for (int t = 1; t <= 8; t++) look(32'h400 + 4*t + (t & 3), "R5");

    // R6 refill resident tag in place
    fill(32'h40A, rnd_line());
    look(32'h409, "R6");
    look(32'h40D, "R6");
    fill(32'h800, rnd_line());
    look(32'h801, "R6");
    look(32'h40B, "R6");

    // R7/R8 shootdown with nonzero low bits
    shoot(32'h100 + 3, 2'b11, 1);
    look(32'h40C, "R7");
    look(32'h408, "R7");
    look(32'h410, "R7");

    // R10 ignored writes
    reg_write(8'h18, 32'h0000_0000 | (32'h104 << 2));
    chk(reg_rdata === 32'h0, "R10", "no busy when bit30 clear", 64'(reg_rdata), 64'h0);
    reg_write(8'h1C, 32'h4000_0000 | (32'h104 << 2));
    chk(reg_rdata === 32'h0, "R10", "no busy at other offset", 64'(reg_rdata), 64'h0);
    look(32'h412, "R10");
    // R10 shootdown during busy ignored
    reg_write(8'h18, 32'h4000_0000 | (32'h104 << 2));
    reg_write(8'h18, 32'h4000_0000 | (32'h105 << 2));
    tick();
    chk(reg_rdata === 32'h0, "R10", "busy not extended", 64'(reg_rdata), 64'h0);
    for (int i = 0; i < LINES; i++) if (m_tag[i] == 32'h104) m_val[i] = 0;
    look(32'h410, "R10");
    look(32'h415, "R10");

    // R9 clear
    run_clear(0, cnt);
    chk(cnt == LINES, "R9", "clear busy length", 64'(cnt), 64'(LINES));
    look(32'h415, "R9");
    look(32'h801, "R9");
    fill(32'h500, rnd_line());
    run_clear(1, cnt);
    chk(cnt == LINES, "R10", "clear not extended", 64'(cnt), 64'(LINES));
    look(32'h502, "R9");
    m_ptr = m_ptr; // pointer persists across clear

    // random mix over a small tag set
    for (int n = 0; n < 600; n++) begin
      int unsigned r = $urandom % 100;
      int unsigned vpn = 32'h2000 + ($urandom % 48);
      if (r < 30)      fill(vpn, rnd_line());
      else if (r < 92) look(vpn, "R3");
      else             shoot(vpn >> 2, 2'($urandom), 1);
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule